// File: doc/BRIEF.md
# UART FIFO Threshold and Error Interrupt Status

This block produces the interrupt status word and the interrupt request line for a serial port. Two level flags are computed live from the occupancy counts of the transmit and receive FIFOs, each against its own 3-bit programmable threshold. The two comparisons point in opposite directions. The transmit flag asserts while the transmit FIFO is drained down to its threshold. The receive flag asserts once the receive FIFO has filled up to its threshold.

Four error sources (overrun, break, parity error, framing error) are captured as sticky flags. Hardware sets a flag with a one-cycle pulse, and software clears it by writing a 1 to its bit through a write port. Each of the six flags is gated by a matching enable bit to form an indicator in the upper byte of the status word. The interrupt line is the OR of those indicators. The FIFOs, the serial engines and the register decode sit outside this block.

The block has no state machine. Its only state is the four sticky flags, which are registered. The level flags, the indicators and the interrupt line are combinational from the inputs and the sticky state. The transitions of each sticky flag are named in the requirements: set, clear, and hold.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, status bits 2 to 5 (the sticky error flags) read 0.
- R2: Status bit 0 is 1 exactly when the transmit count is less than or equal to `tx_thr`, in the same cycle as the inputs.
- R3: Status bit 1 is 1 exactly when the receive count is greater than or equal to `rx_thr`, in the same cycle as the inputs.
- R4: A 1 on `err_set[k]` sets status bit 2+k (k=0 overrun, 1 break, 2 parity, 3 frame) from the next clock edge on. The flag stays 1 after the pulse ends.
- R5: A write with `wr_data[2+k]`=1 clears sticky flag k at that clock edge. A write with that bit at 0 leaves the flag unchanged.
- R6: When a set pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up 1.
- R7: Status bit 8+i equals status bit i AND `irq_en[i]`, for i = 0 to 5.
- R8: `irq` equals the OR of status bits 8 to 13.
- R9: Writes to status bits 0, 1 and 8 to 15 change nothing. Status bits 6, 7, 14 and 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_thr | input | THR_W | Transmit threshold (threshold register bits 2:0) |
| rx_thr | input | THR_W | Receive threshold (threshold register bits 6:4) |
| err_set | input | 4 | Set pulses: overrun, break, parity, frame |
| irq_en | input | 6 | Per-source enable, bit i gates status bit i |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 16 | Status write data, 1 clears a sticky bit |
| status | output | 16 | Status word: flags 5:0, indicators 13:8 |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle that a set pulse always leaves its flag at 1 on the next edge, even against a clear. They also check that a clear with no set leaves the flag at 0, and that a flag with neither input holds its value. Every cycle they further check that the two level flags agree with their comparisons, that no indicator is up without its enable, and that the interrupt line matches the indicators. The directed scenarios add what only a sequence shows: the exact boundary values of both threshold comparisons, that a write of 0 and writes to the live and indicator bits leave the state untouched, and the reset value.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NUM_LVL  = 2;
    localparam int NUM_ERR  = 4;
    localparam int NUM_SRC  = NUM_LVL + NUM_ERR;
    localparam int STAT_W   = 16;
    localparam int IND_LSB  = 8;

    // Positions of the sources in the status word; the indicator of source s sits at IND_LSB+s.
    typedef enum logic [2:0] {
        SRC_TX_LVL = 3'd0,
        SRC_RX_LVL = 3'd1,
        SRC_OVR    = 3'd2,
        SRC_BRK    = 3'd3,
        SRC_PAR    = 3'd4,
        SRC_FRM    = 3'd5
    } irq_src_e;
endpackage

// File: rtl/uirq_level_cmp.sv
module uirq_level_cmp #(
    parameter int CNT_W = 4,
    parameter int THR_W = 3
) (
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    output logic             tx_lvl,
    output logic             rx_lvl
);
    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic [CMP_W-1:0] tx_c, rx_c, tx_t, rx_t;

    always_comb begin
        tx_c   = CMP_W'(tx_cnt);
        rx_c   = CMP_W'(rx_cnt);
        tx_t   = CMP_W'(tx_thr);
        rx_t   = CMP_W'(rx_thr);
        // Opposite senses: transmit drains toward threshold, receive fills toward it.
        tx_lvl = (tx_c <= tx_t);
        rx_lvl = (rx_c >= rx_t);
    end
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[k] <= 1'b0;
            end else if (set_i[k]) begin
                flag_q[k] <= 1'b1;          // set has priority over clear
            end else if (clr_i[k]) begin
                flag_q[k] <= 1'b0;
            end
        end

        a_r6_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flag_q[k]);
        a_r5_clear : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flag_q[k]);
        a_r4_hold : assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[k] && !set_i[k]) |=> $stable(flag_q[k]));
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/uirq_mask.sv
module uirq_mask #(
    parameter int N = 6
) (
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] ind_o,
    output logic         irq_o
);
    always_comb begin
        ind_o = flags_i & en_i;
        irq_o = |ind_o;
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int THR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [THR_W-1:0]  tx_thr,
    input  logic [THR_W-1:0]  rx_thr,
    input  logic [NUM_ERR-1:0] err_set,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    localparam int ERR_LSB = int'(SRC_OVR);

    logic               tx_lvl, rx_lvl;
    logic [NUM_ERR-1:0] err_clr, err_flag;
    logic [NUM_SRC-1:0] flags, ind;
    logic               unused_wr;

    // Only the sticky positions of the write data act; the rest is dropped.
    assign err_clr   = wr_en ? wr_data[ERR_LSB +: NUM_ERR] : '0;
    assign unused_wr = ^{wr_data[STAT_W-1:ERR_LSB+NUM_ERR], wr_data[ERR_LSB-1:0]};

    uirq_level_cmp #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cmp (
        .tx_cnt (tx_count),
        .rx_cnt (rx_count),
        .tx_thr (tx_thr),
        .rx_thr (rx_thr),
        .tx_lvl (tx_lvl),
        .rx_lvl (rx_lvl)
    );

    uirq_sticky #(.N(NUM_ERR)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_set),
        .clr_i  (err_clr),
        .flag_o (err_flag)
    );

    assign flags = {err_flag, rx_lvl, tx_lvl};

    uirq_mask #(.N(NUM_SRC)) u_mask (
        .flags_i (flags),
        .en_i    (irq_en),
        .ind_o   (ind),
        .irq_o   (irq)
    );

    always_comb begin
        status = '0;
        status[NUM_SRC-1:0]            = flags;
        status[IND_LSB +: NUM_SRC]     = ind;
    end

    a_r2_tx_level : assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_count) <= int'(tx_thr)) == status[SRC_TX_LVL]);
    a_r3_rx_level : assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_count) >= int'(rx_thr)) == status[SRC_RX_LVL]);
    a_r7_needs_enable : assert property (@(posedge clk) disable iff (!rst_n)
        (status[IND_LSB +: NUM_SRC] & ~irq_en) == '0);
    a_r8_irq_line : assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status[IND_LSB +: NUM_SRC] != '0));
    a_r9_spare_zero : assert property (@(posedge clk) disable iff (!rst_n)
        status[7:6] == 2'b00 && status[15:14] == 2'b00);
endmodule

// File: tb/uart_irq_status_tb_top.sv
`timescale 1ns/1ps
module uart_irq_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tx_count = '0, rx_count = '0;
    logic [2:0]  tx_thr = '0, rx_thr = '0;
    logic [3:0]  err_set = '0;
    logic [5:0]  irq_en = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] status;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_status dut_i (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
        .tx_thr(tx_thr), .rx_thr(rx_thr), .err_set(err_set), .irq_en(irq_en),
        .wr_en(wr_en), .wr_data(wr_data), .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle pulse on the sticky set inputs, optionally with a write in the same cycle.
    task automatic cycle(input logic [3:0] set, input logic we, input logic [15:0] wd);
        @(negedge clk);
        err_set = set; wr_en = we; wr_data = wd;
        @(negedge clk);
        err_set = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        chk("R1 sticky cleared by reset", {12'd0, status[5:2]}, 16'h0000);
        chk("R9 spare bits zero at reset", {12'd0, status[15:14], status[7:6]}, 16'h0000);
    endtask

    task automatic t_tx_level();
        for (int thr = 0; thr < 8; thr += 3) begin
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                tx_thr = 3'(thr); tx_count = 4'(c);
                #1;
                chk("R2 tx level flag", {15'd0, status[0]}, {15'd0, (c <= thr)});
            end
        end
        tx_count = 4'd9; tx_thr = 3'd0; #1;
    endtask

    task automatic t_rx_level();
        for (int thr = 0; thr < 8; thr += 7) begin
            for (int c = 0; c < 16; c += 3) begin
                @(negedge clk);
                rx_thr = 3'(thr); rx_count = 4'(c);
                #1;
                chk("R3 rx level flag", {15'd0, status[1]}, {15'd0, (c >= thr)});
            end
        end
        @(negedge clk);
        rx_thr = 3'd7; rx_count = 4'd6; #1;
        chk("R3 rx below threshold", {15'd0, status[1]}, 16'h0000);
        rx_count = 4'd7; #1;
        chk("R3 rx at threshold", {15'd0, status[1]}, 16'h0001);
        rx_count = 4'd0; #1;
    endtask

    task automatic t_sticky_set();
        for (int k = 0; k < 4; k++) begin
            cycle(4'(1 << k), 1'b0, 16'h0);
            chk("R4 set pulse latches", {12'd0, status[5:2]}, 16'((1 << (k + 1)) - 1));
        end
        cycle(4'b0000, 1'b0, 16'h0);
        chk("R4 flags hold with no input", {12'd0, status[5:2]}, 16'h000F);
    endtask

    task automatic t_w1c();
        cycle(4'b0000, 1'b1, 16'h0000);
        chk("R5 write of zero keeps flags", {12'd0, status[5:2]}, 16'h000F);
        cycle(4'b0000, 1'b1, 16'h0014);
        chk("R5 write one clears ovr and par", {12'd0, status[5:2]}, 16'h000A);
        cycle(4'b0000, 1'b0, 16'h003C);
        chk("R5 data without strobe ignored", {12'd0, status[5:2]}, 16'h000A);
    endtask

    task automatic t_set_wins();
        cycle(4'b1010, 1'b1, 16'h0028);
        chk("R6 set beats clear", {12'd0, status[5:2]}, 16'h000A);
        cycle(4'b0000, 1'b1, 16'h003C);
        chk("R5 clear all sticky", {12'd0, status[5:2]}, 16'h0000);
    endtask

    task automatic t_mask_irq();
        // Level flags: tx=9 thr 0 -> 0; rx=0 thr 7 -> 0. Set brk only.
        cycle(4'b0010, 1'b0, 16'h0);
        irq_en = 6'b110111; #1;
        chk("R7 brk masked off", {10'd0, status[13:8]}, 16'h0000);
        chk("R8 irq low with no indicator", {15'd0, irq}, 16'h0000);
        irq_en = 6'b001000; #1;
        chk("R7 brk indicator", {10'd0, status[13:8]}, 16'h0008);
        chk("R8 irq high", {15'd0, irq}, 16'h0001);
        tx_count = 4'd0; irq_en = 6'b111111; #1;
        chk("R7 tx level and brk indicators", {10'd0, status[13:8]}, 16'h0009);
        tx_count = 4'd9; irq_en = 6'b000000; #1;
        chk("R8 irq low all masked", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_ignored_bits();
        tx_count = 4'd0; rx_count = 4'd7; irq_en = 6'b111111; #1;
        cycle(4'b0000, 1'b1, 16'hFFC3);
        chk("R9 writes to live/indicator bits ignored", status, 16'h0B0B);
        chk("R9 irq unchanged", {15'd0, irq}, 16'h0001);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_level();
        t_rx_level();
        t_sticky_set();
        t_w1c();
        t_set_wins();
        t_mask_irq();
        t_ignored_bits();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule